// File: doc/BRIEF.md
# Static Memory Strobe Sequencer

This block produces the chip-select, read-strobe and write-strobe waveforms for a single chip select on an asynchronous static memory bus. All timing is counted in clock cycles. Each strobe has its own setup and pulse lengths, and reads and writes each have their own total length. All of these come in as compressed codes, and the block expands them into wide cycle counts. Every setup count is measured from the first cycle of the address phase. Chip select is not the reference point.

A request is accepted through a valid/ready handshake, and only while the block is idle. On acceptance the block captures the address, the direction and every timing code. It then holds the address and the write-data enable for the whole access and drives the strobes low in their windows. A one-cycle completion pulse marks the final cycle of the access. An optional write mode keeps chip select asserted past the release of the write strobe. The block does not check the programmed values for consistency.

Top module: `ext_mem_strobe_gen`

## Requirements
- R1: A 6-bit setup code c expands to 128*c[5] + c[4:0] cycles, giving 0..31 or 128..159.
- R2: A 7-bit pulse code c expands to 256*c[6] + c[5:0] cycles, giving 0..63 or 256..319.
- R3: A 9-bit cycle code c expands to 256*c[8:7] + c[6:0] cycles. An access occupies exactly that many cycles, numbered 0 to N-1 from the cycle after the accepting clock edge.
- R4: The active strobe (rd_n for reads, we_n for writes) is low in cycles S to S+P-1, where S is its expanded setup and P is its expanded pulse. It is high in every other cycle.
- R5: cs_n is low in cycles Sc to Sc+Pc-1. Sc and Pc are taken from the chip-select setup and pulse codes of the access direction, which are separate for reads and writes.
- R6: After reset the block is idle: req_ready is 1, cs_n, rd_n and we_n are 1, and done is 0. req_ready is 0 for the whole access, and a request is accepted only on a clock edge where both req_valid and req_ready are 1.
- R7: done is high for exactly one cycle, in cycle N-1 of the access.
- R8: The timing codes, the mode bit, the address and the direction are sampled when a request is accepted. Changes to them during an access have no effect on that access.
- R9: When the write-mode bit wr_hold_cs is 1 on a write, cs_n stays low through cycle E, where E is the cycle in which we_n returns high. The end of the access still cuts it off. When the bit is 0, R5 alone applies.
- R10: mem_addr holds the accepted address throughout an access. mem_wdata_oe is 1 only during write accesses. rd_n never goes low on a write, and we_n never goes low on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High when idle and able to accept |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | AW | Access address |
| wr_hold_cs | input | 1 | Keep chip select active past write-strobe release |
| rd_setup_code | input | 6 | Read strobe setup code |
| rd_cs_setup_code | input | 6 | Chip-select setup code for reads |
| wr_setup_code | input | 6 | Write strobe setup code |
| wr_cs_setup_code | input | 6 | Chip-select setup code for writes |
| rd_pulse_code | input | 7 | Read strobe pulse code |
| rd_cs_pulse_code | input | 7 | Chip-select pulse code for reads |
| wr_pulse_code | input | 7 | Write strobe pulse code |
| wr_cs_pulse_code | input | 7 | Chip-select pulse code for writes |
| rd_cycle_code | input | 9 | Read access length code |
| wr_cycle_code | input | 9 | Write access length code |
| mem_addr | output | AW | Address held during the access |
| mem_wdata_oe | output | 1 | Write data drive enable |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
A strobe's release can fall in the same cycle as the end of the access, when setup plus pulse equals the cycle count. The bench provokes this with a read whose strobe window runs to the last cycle. It then requires the strobe to stay low through the done cycle and to read high in the first idle cycle. A second collision comes from the write-mode extension: the chip-select end is pushed out to one past the write-strobe release. The bench checks that the extended low phase of cs_n still covers the release cycle, and that it ends exactly one cycle after it.

// File: rtl/ext_mem_strobe_gen.sv
module ext_mem_strobe_gen #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          wr_hold_cs,
  input  logic [5:0]    rd_setup_code,
  input  logic [5:0]    rd_cs_setup_code,
  input  logic [5:0]    wr_setup_code,
  input  logic [5:0]    wr_cs_setup_code,
  input  logic [6:0]    rd_pulse_code,
  input  logic [6:0]    rd_cs_pulse_code,
  input  logic [6:0]    wr_pulse_code,
  input  logic [6:0]    wr_cs_pulse_code,
  input  logic [8:0]    rd_cycle_code,
  input  logic [8:0]    wr_cycle_code,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wdata_oe,
  output logic          cs_n,
  output logic          rd_n,
  output logic          we_n,
  output logic          done
);
  localparam int NW = 10;

  function automatic logic [NW-1:0] exp_setup(input logic [5:0] c);
    return NW'({c[5], 2'b00, c[4:0]});
  endfunction
  function automatic logic [NW-1:0] exp_pulse(input logic [6:0] c);
    return NW'({c[6], 2'b00, c[5:0]});
  endfunction
  function automatic logic [NW-1:0] exp_cycle(input logic [8:0] c);
    return NW'({c[8:7], 1'b0, c[6:0]});
  endfunction

  logic          busy, q_wr, q_hold;
  logic [NW-1:0] cnt, q_ss, q_se, q_cs, q_ce, q_last;
  logic [AW-1:0] q_addr;

  logic [NW-1:0] n_ss, n_se, n_cs, n_ce0, n_ce, n_cyc, n_last;
  logic          accept;

  assign accept = req_valid && !busy;

  assign n_ss  = req_write ? exp_setup(wr_setup_code)    : exp_setup(rd_setup_code);
  assign n_cs  = req_write ? exp_setup(wr_cs_setup_code) : exp_setup(rd_cs_setup_code);
  assign n_se  = n_ss + (req_write ? exp_pulse(wr_pulse_code)    : exp_pulse(rd_pulse_code));
  assign n_ce0 = n_cs + (req_write ? exp_pulse(wr_cs_pulse_code) : exp_pulse(rd_cs_pulse_code));
  assign n_ce  = (req_write && wr_hold_cs && (n_ce0 <= n_se)) ? n_se + NW'(1) : n_ce0;
  assign n_cyc = req_write ? exp_cycle(wr_cycle_code) : exp_cycle(rd_cycle_code);
  assign n_last = (n_cyc == '0) ? '0 : n_cyc - NW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      q_wr   <= 1'b0;
      q_hold <= 1'b0;
      q_ss   <= '0;
      q_se   <= '0;
      q_cs   <= '0;
      q_ce   <= '0;
      q_last <= '0;
      q_addr <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      q_wr   <= req_write;
      q_hold <= wr_hold_cs;
      q_ss   <= n_ss;
      q_se   <= n_se;
      q_cs   <= n_cs;
      q_ce   <= n_ce;
      q_last <= n_last;
      q_addr <= req_addr;
    end else if (busy) begin
      if (cnt == q_last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + NW'(1);
      end
    end
  end

  logic strb_on;
  assign strb_on      = busy && (cnt >= q_ss) && (cnt < q_se);
  assign rd_n         = !(strb_on && !q_wr);
  assign we_n         = !(strb_on && q_wr);
  assign cs_n         = !(busy && (cnt >= q_cs) && (cnt < q_ce));
  assign done         = busy && (cnt == q_last);
  assign req_ready    = !busy;
  assign mem_addr     = q_addr;
  assign mem_wdata_oe = busy && q_wr;

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && rd_n && we_n && !mem_wdata_oe));
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> $stable(mem_addr));
  p_no_cross_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !we_n));
  p_rd_only_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !mem_wdata_oe);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= q_last));
  p_cs_covers_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && q_hold && q_wr && $past(!we_n) && we_n && (q_cs < q_se)) |-> !cs_n);
endmodule

// File: tb/ext_mem_strobe_gen_tb.sv
module ext_mem_strobe_gen_tb;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, wr_hold_cs = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [5:0] rd_s = '0, rd_cs_s = '0, wr_s = '0, wr_cs_s = '0;
  logic [6:0] rd_p = '0, rd_cs_p = '0, wr_p = '0, wr_cs_p = '0;
  logic [8:0] rd_c = '0, wr_c = '0;
  logic req_ready, mem_wdata_oe, cs_n, rd_n, we_n, done;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ext_mem_strobe_gen #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .wr_hold_cs(wr_hold_cs),
    .rd_setup_code(rd_s), .rd_cs_setup_code(rd_cs_s),
    .wr_setup_code(wr_s), .wr_cs_setup_code(wr_cs_s),
    .rd_pulse_code(rd_p), .rd_cs_pulse_code(rd_cs_p),
    .wr_pulse_code(wr_p), .wr_cs_pulse_code(wr_cs_p),
    .rd_cycle_code(rd_c), .wr_cycle_code(wr_c),
    .mem_addr(mem_addr), .mem_wdata_oe(mem_wdata_oe),
    .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n), .done(done)
  );

  function automatic int sv(input logic [5:0] c); return 128*c[5] + c[4:0]; endfunction
  function automatic int pv(input logic [6:0] c); return 256*c[6] + c[5:0]; endfunction
  function automatic int cv(input logic [8:0] c); return 256*c[8:7] + c[6:0]; endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int r_sl, r_sh, r_cl, r_ch, r_done, r_ndone, r_other, r_busyrdy, r_addrbad, r_oebad, r_len;

  task automatic run_access(input logic wr, input logic [AW-1:0] addr, input bit scramble);
    logic [AW-1:0] a_exp;
    r_sl = -1; r_sh = -1; r_cl = -1; r_ch = -1; r_done = -1; r_ndone = 0;
    r_other = 0; r_busyrdy = 0; r_addrbad = 0; r_oebad = 0; r_len = 0;
    a_exp = addr;
    @(negedge clk);
    req_write = wr; req_addr = addr; req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (scramble) begin
      rd_s = 6'h1F; rd_cs_s = 6'h3F; rd_p = 7'h7F; rd_cs_p = 7'h01; rd_c = 9'h1FF;
      wr_s = 6'h1F; wr_cs_s = 6'h3F; wr_p = 7'h7F; wr_cs_p = 7'h01; wr_c = 9'h1FF;
      wr_hold_cs = ~wr_hold_cs; req_write = ~wr; req_addr = ~addr;
    end
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      r_len++;
      if (req_ready) r_busyrdy++;
      if (mem_addr !== a_exp) r_addrbad++;
      if (mem_wdata_oe !== wr) r_oebad++;
      if (((wr ? we_n : rd_n) == 1'b0) && r_sl < 0) r_sl = k;
      if (((wr ? we_n : rd_n) == 1'b1) && r_sl >= 0 && r_sh < 0) r_sh = k;
      if ((wr ? rd_n : we_n) == 1'b0) r_other++;
      if (cs_n == 1'b0 && r_cl < 0) r_cl = k;
      if (cs_n == 1'b1 && r_cl >= 0 && r_ch < 0) r_ch = k;
      if (done) begin r_ndone++; r_done = k; end
      if (done) break;
    end
    @(negedge clk);
    if (r_sh < 0 && (wr ? we_n : rd_n)) r_sh = r_len;
    if (r_ch < 0 && cs_n) r_ch = r_len;
    chk("R6", "ready after access", req_ready, 1);
    chk("R7", "done after access", done, 0);
  endtask

  task automatic check_common(input string tag, input int s, input int p, input int cs, input int cp, input int n);
    chk({tag, " R4"}, "strobe low first cycle", r_sl, s);
    chk({tag, " R4"}, "strobe high again cycle", r_sh, s + p);
    chk({tag, " R5"}, "cs low first cycle", r_cl, cs);
    chk({tag, " R5"}, "cs high again cycle", r_ch, cs + cp);
    chk({tag, " R3"}, "access length", r_len, n);
    chk({tag, " R7"}, "done cycle", r_done, n - 1);
    chk({tag, " R7"}, "done pulses", r_ndone, 1);
    chk({tag, " R6"}, "ready seen while busy", r_busyrdy, 0);
    chk({tag, " R10"}, "address glitches", r_addrbad, 0);
    chk({tag, " R10"}, "oe mismatches", r_oebad, 0);
    chk({tag, " R10"}, "wrong strobe low", r_other, 0);
  endtask

  task automatic t_reset;
    chk("R6", "reset ready", req_ready, 1);
    chk("R6", "reset cs_n", cs_n, 1);
    chk("R6", "reset rd_n", rd_n, 1);
    chk("R6", "reset we_n", we_n, 1);
    chk("R6", "reset done", done, 0);
  endtask

  task automatic t_read_low;
    rd_s = 6'd2; rd_p = 7'd5; rd_cs_s = 6'd0; rd_cs_p = 7'd9; rd_c = 9'd12;
    run_access(1'b0, 24'h00ABCD, 1'b0);
    check_common("read low R1 R2", sv(6'd2), pv(7'd5), 0, 9, 12);
  endtask

  task automatic t_read_high;
    rd_s = 6'h21; rd_p = 7'h7F; rd_cs_s = 6'h3F; rd_cs_p = 7'h41; rd_c = 9'h185;
    chk("R1", "setup 0x21", sv(6'h21), 129);
    chk("R2", "pulse 0x7F", pv(7'h7F), 319);
    chk("R3", "cycle 0x185", cv(9'h185), 773);
    run_access(1'b0, 24'h123456, 1'b0);
    check_common("read high R1 R2 R3", 129, 319, 159, 257, 773);
  endtask

  task automatic t_write_mid;
    wr_hold_cs = 1'b0;
    wr_s = 6'h23; wr_p = 7'h3F; wr_cs_s = 6'h01; wr_cs_p = 7'h44; wr_c = 9'h0A5;
    run_access(1'b1, 24'h0F0F0F, 1'b0);
    check_common("write mid R1 R2 R3", 131, 63, 1, 260, 293);
    wr_c = 9'h10A;
    run_access(1'b1, 24'h000777, 1'b0);
    check_common("write range2 R3", 131, 63, 1, 260, 522);
  endtask

  task automatic t_hold_mode;
    wr_s = 6'd1; wr_p = 7'd4; wr_cs_s = 6'd0; wr_cs_p = 7'd5; wr_c = 9'd10;
    wr_hold_cs = 1'b0;
    run_access(1'b1, 24'h000010, 1'b0);
    check_common("hold off R9", 1, 4, 0, 5, 10);
    wr_hold_cs = 1'b1;
    run_access(1'b1, 24'h000020, 1'b0);
    chk("R9", "cs high again with hold", r_ch, 6);
    chk("R9", "we release cycle", r_sh, 5);
    wr_hold_cs = 1'b0;
  endtask

  task automatic t_coincide;
    rd_s = 6'd3; rd_p = 7'd7; rd_cs_s = 6'd1; rd_cs_p = 7'd9; rd_c = 9'd10;
    run_access(1'b0, 24'h000099, 1'b0);
    check_common("coincide R4 R7", 3, 7, 1, 9, 10);
    chk("R4", "rd_n idle after", rd_n, 1);
  endtask

  task automatic t_sampled;
    rd_s = 6'd4; rd_p = 7'd3; rd_cs_s = 6'd2; rd_cs_p = 7'd6; rd_c = 9'd11;
    wr_hold_cs = 1'b0;
    run_access(1'b0, 24'h0000C3, 1'b1);
    check_common("sampled R8", 4, 3, 2, 6, 11);
    wr_hold_cs = 1'b0;
  endtask

  task automatic t_valid_held;
    rd_s = 6'd1; rd_p = 7'd2; rd_cs_s = 6'd0; rd_cs_p = 7'd4; rd_c = 9'd6;
    @(negedge clk);
    req_write = 1'b0; req_addr = 24'h000055; req_valid = 1'b1;
    @(posedge clk);
    #1;
    begin
      int rdy_busy = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (req_ready) rdy_busy++;
        if (k == 2) req_addr = 24'h0000AA;
      end
      chk("R6", "ready while busy with valid held", rdy_busy, 0);
      chk("R8", "address kept from acceptance", mem_addr, 24'h000055);
    end
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_low();
    t_read_high();
    t_write_mid();
    t_hold_mode();
    t_coincide();
    t_sampled();
    t_valid_held();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule